// File: doc/BRIEF.md
# Triggered Program Trace Buffer

This block keeps a history of the steps a processor core executes. Every cycle in which the core commits a step, it presents the fetched program address and one data word. While the buffer is armed, those steps go into a circular on-chip array. A trigger input, usually driven by a breakpoint comparator, decides where the kept history ends. The history can end at the trigger, start at the trigger, or straddle it, with half the array on each side.

An optional address window limits recording to steps whose program address lies between an inclusive lower and upper bound. The array then holds only code in the region of interest. Once capture has stopped, a debug agent pulses a start strobe and then a next strobe to walk the entries from oldest to newest. A saturating count tells it how many entries are valid. Arming again discards the previous capture and starts a new one.

Top module: `trc_buffer`

## Requirements
- R1: After reset the buffer is disarmed: `count` is 0 and both `armed` and `done` are low.
- R2: A pulse on `arm` clears `count` to 0, sets `armed`, clears `done` and latches `mode`. No step is recorded in the arm cycle, and `arm` takes priority over `trig`.
- R3: With mode 2'b00 (stop at trigger), every accepted step before the trigger is recorded. The step in the trigger cycle is not recorded, and `done` rises after that clock edge.
- R4: With mode 2'b01 (start at trigger), nothing is recorded before the trigger. Recording starts with the step in the trigger cycle. `done` rises after DEPTH steps have been written from that point.
- R5: With mode 2'b10 (around trigger), steps are recorded both before and from the trigger cycle. `done` rises after DEPTH/2 steps have been written from the trigger cycle on.
- R6: Storage is circular: once DEPTH entries have been written, each new step overwrites the oldest one. `count` increases by one per write and saturates at DEPTH.
- R7: With `qual_en` high, only steps with `win_lo <= step_pc <= win_hi` are written. With `qual_en` low, every step is written.
- R8: A pulse on `rd_start` selects the oldest entry. That is entry 0 when `count` < DEPTH, and the next write slot when `count` = DEPTH. Each `rd_next` pulse advances one entry, wrapping at the end of the array. The selected `step_pc` and `step_data` appear on `rd_pc` and `rd_data` one cycle after the strobe.
- R9: A trigger that arrives while the buffer is disarmed or already done is ignored: `count`, `done` and the stored entries are unchanged.
- R10: A cycle with `step_valid` low writes nothing, and `count` is unchanged.
- R11: Mode 2'b11 behaves the same as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start a new capture (one-cycle pulse) |
| mode | input | 2 | Capture placement: 00 before, 01 after, 10 around, 11 as 00 |
| qual_en | input | 1 | Enable the address window qualifier |
| win_lo | input | PC_W | Inclusive lower address bound |
| win_hi | input | PC_W | Inclusive upper address bound |
| step_valid | input | 1 | A step is committed this cycle |
| step_pc | input | PC_W | Program address of the step |
| step_data | input | DAT_W | Data word recorded with the step |
| trig | input | 1 | Trigger event |
| rd_start | input | 1 | Select the oldest entry for readout |
| rd_next | input | 1 | Advance readout by one entry |
| rd_pc | output | PC_W | Address field of the selected entry |
| rd_data | output | DAT_W | Data field of the selected entry |
| count | output | CNT_W | Number of valid entries, saturating at DEPTH |
| armed | output | 1 | Capture in progress |
| done | output | 1 | Capture finished |

## Verification
The hardest case to reach is a wrapped buffer whose oldest entry sits in the middle of the array. It occurs only after more qualified steps than DEPTH, and then only in stop-at-trigger or around-trigger mode. The bench uses a reduced depth of 16 and streams runs longer than that, so readout must start at the write pointer and wrap back through entry 0. A qualified post-trigger run that never fills its budget leaves the block armed but not done. That case checks that the budget counts only writes, not raw steps.

// File: rtl/trc_pkg.sv
// Shared types for the trace buffer: capture mode codes and sequencer states.
package trc_pkg;

    // Placement of the kept window relative to the trigger.
    typedef enum logic [1:0] {
        TM_BEFORE = 2'b00,
        TM_AFTER  = 2'b01,
        TM_AROUND = 2'b10,
        TM_SPARE  = 2'b11
    } trc_mode_e;

    // Capture sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FILL   = 2'b01,
        ST_DRAIN  = 2'b10,
        ST_FROZEN = 2'b11
    } trc_state_e;

endpackage

// File: rtl/trc_window.sv
// Address window qualifier.
// Decides whether a committed step may be recorded. With HAS_QUAL = 1 the
// step must fall inside the inclusive [lo, hi] range when enabled; with
// HAS_QUAL = 0 the comparators are not built and every valid step passes.
// Assumes lo <= hi when the window is enabled; otherwise nothing passes.
module trc_window #(
    parameter int PC_W     = 16,
    parameter bit HAS_QUAL = 1'b1
) (
    input  logic            step_valid,
    input  logic            qual_en,
    input  logic [PC_W-1:0] win_lo,
    input  logic [PC_W-1:0] win_hi,
    input  logic [PC_W-1:0] step_pc,
    output logic            step_ok
);

    generate
        if (HAS_QUAL) begin : g_qual
            // Range compare on the step address.
            always_comb begin
                step_ok = step_valid &&
                          (!qual_en || ((step_pc >= win_lo) && (step_pc <= win_hi)));
            end
        end else begin : g_noqual
            logic unused_qual;
            // No qualifier: pass every valid step.
            always_comb begin
                unused_qual = qual_en ^ (^win_lo) ^ (^win_hi) ^ (^step_pc);
                step_ok     = step_valid;
            end
        end
    endgenerate

endmodule

// File: rtl/trc_seq.sv
// Capture sequencer.
// Tracks the arm/fill/drain/frozen phases, produces the write enable and the
// circular write pointer, keeps the saturating valid count and the
// post-trigger budget, and reports the oldest entry for readout.
// Assumes DEPTH >= 2 so the around-trigger budget is at least one write.
module trc_seq
    import trc_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [1:0]       mode,
    input  logic             step_ok,
    input  logic             trig,
    output logic             we,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] oldest,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             done
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    trc_state_e       state_q, state_d;
    trc_mode_e        mode_q;
    logic [CNT_W-1:0] left_q, left_d;
    logic [CNT_W-1:0] budget;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] wptr_q;

    // Writes allowed from the trigger cycle onward, by latched mode.
    always_comb begin
        case (mode_q)
            TM_AFTER:  budget = FULL_CNT;
            TM_AROUND: budget = HALF_CNT;
            default:   budget = '0;
        endcase
    end

    // Next-state, budget and write-enable decision.
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        we      = 1'b0;
        case (state_q)
            ST_FILL: begin
                if (trig) begin
                    if (budget == '0) begin
                        state_d = ST_FROZEN;
                    end else begin
                        we      = step_ok;
                        left_d  = budget - CNT_W'(step_ok);
                        state_d = (left_d == '0) ? ST_FROZEN : ST_DRAIN;
                    end
                end else begin
                    we = step_ok && (mode_q != TM_AFTER);
                end
            end
            ST_DRAIN: begin
                if (step_ok) begin
                    we     = 1'b1;
                    left_d = left_q - 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        state_d = ST_FROZEN;
                    end
                end
            end
            default: ;
        endcase
        if (arm) begin
            state_d = ST_FILL;
            left_d  = '0;
            we      = 1'b0;
        end
    end

    // Sequencer state, latched mode and remaining budget.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= TM_BEFORE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            if (arm) begin
                mode_q <= trc_mode_e'(mode);
            end
        end
    end

    // Circular write pointer and saturating valid count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            count_q <= '0;
        end else if (arm) begin
            wptr_q  <= '0;
            count_q <= '0;
        end else if (we) begin
            wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
            if (count_q != FULL_CNT) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // Status and readout start point.
    always_comb begin
        wptr   = wptr_q;
        count  = count_q;
        oldest = (count_q == FULL_CNT) ? wptr_q : '0;
        armed  = (state_q == ST_FILL) || (state_q == ST_DRAIN);
        done   = (state_q == ST_FROZEN);
    end

endmodule

// File: rtl/trc_store.sv
// Trace storage array with its readout pointer.
// Holds DEPTH entries of ENT_W bits. Writes land at the write pointer.
// Readout keeps its own pointer: a start strobe loads the oldest index, a
// next strobe advances with wrap. The selected entry is registered, so it
// appears one cycle after the strobe. Assumes readout runs after capture
// has stopped; a read and a write of the same slot return the old entry.
module trc_store #(
    parameter int DEPTH = 512,
    parameter int ENT_W = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] wptr,
    input  logic [ENT_W-1:0] wdata,
    input  logic             rd_start,
    input  logic             rd_next,
    input  logic [PTR_W-1:0] oldest,
    output logic [ENT_W-1:0] rdata
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rptr_q, rptr_d;
    logic [ENT_W-1:0] rdata_q;

    // Next readout index: start has priority over advance.
    always_comb begin
        rptr_d = rptr_q;
        if (rd_start) begin
            rptr_d = oldest;
        end else if (rd_next) begin
            rptr_d = (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
        end
    end

    // Array write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wptr] <= wdata;
        end
    end

    // Readout pointer and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            rdata_q <= '0;
        end else begin
            rptr_q  <= rptr_d;
            rdata_q <= mem[rptr_d];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/trc_buffer.sv
// Triggered program trace buffer (top).
// Qualifies each committed step against an optional address window, lets
// the sequencer decide whether it is written given the capture mode and
// trigger, stores address and data in a circular array and offers an
// oldest-first readout. Assumes single-cycle arm/trig/rd strobes and a
// synchronous active-low reset.
module trc_buffer #(
    parameter int DEPTH    = 512,
    parameter int PC_W     = 16,
    parameter int DAT_W    = 16,
    parameter bit HAS_QUAL = 1'b1,
    parameter int PTR_W    = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [1:0]       mode,
    input  logic             qual_en,
    input  logic [PC_W-1:0]  win_lo,
    input  logic [PC_W-1:0]  win_hi,
    input  logic             step_valid,
    input  logic [PC_W-1:0]  step_pc,
    input  logic [DAT_W-1:0] step_data,
    input  logic             trig,
    input  logic             rd_start,
    input  logic             rd_next,
    output logic [PC_W-1:0]  rd_pc,
    output logic [DAT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             done
);

    localparam int ENT_W = PC_W + DAT_W;

    logic             step_ok;
    logic             we;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] oldest;
    logic [ENT_W-1:0] rd_ent;

    trc_window #(
        .PC_W     (PC_W),
        .HAS_QUAL (HAS_QUAL)
    ) u_window (
        .step_valid (step_valid),
        .qual_en    (qual_en),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .step_pc    (step_pc),
        .step_ok    (step_ok)
    );

    trc_seq #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .mode    (mode),
        .step_ok (step_ok),
        .trig    (trig),
        .we      (we),
        .wptr    (wptr),
        .oldest  (oldest),
        .count   (count),
        .armed   (armed),
        .done    (done)
    );

    trc_store #(
        .DEPTH (DEPTH),
        .ENT_W (ENT_W),
        .PTR_W (PTR_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .wptr     (wptr),
        .wdata    ({step_pc, step_data}),
        .rd_start (rd_start),
        .rd_next  (rd_next),
        .oldest   (oldest),
        .rdata    (rd_ent)
    );

    // Split the registered entry into its fields.
    always_comb begin
        rd_pc   = rd_ent[ENT_W-1:DAT_W];
        rd_data = rd_ent[DAT_W-1:0];
    end

endmodule

// File: rtl/trc_buffer_chk.sv
// Port-level property checker for trc_buffer, attached with bind below.
// Assumes the same DEPTH and CNT_W as the instance it watches.
module trc_buffer_chk #(
    parameter int DEPTH = 512,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             step_valid,
    input logic [CNT_W-1:0] count,
    input logic             armed,
    input logic             done
);

    a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (count == '0) && armed && !done);

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

    a_r9_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm) |=> ($stable(count) && (done == $past(done))));

    a_r10_no_step_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !step_valid && !arm) |=> $stable(count));

endmodule

bind trc_buffer trc_buffer_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_trc_buffer_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .step_valid (step_valid),
    .count      (count),
    .armed      (armed),
    .done       (done)
);

// File: tb/test_trc_buffer.sv
// Self-checking bench for trc_buffer with a reduced depth of 16.
module test_trc_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int PC_W       = 16;
    localparam int DAT_W      = 8;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int NCASE      = 9;

    typedef struct packed {
        logic [1:0]  mode;
        logic        qual;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [7:0]  npre;
        logic [7:0]  npost;
    } case_t;

    // mode, qual_en, win_lo, win_hi, steps before trigger, steps from trigger
    localparam case_t CASES [NCASE] = '{
        '{2'b00, 1'b0, 16'h0000, 16'h0000, 8'd5,  8'd3},
        '{2'b00, 1'b0, 16'h0000, 16'h0000, 8'd20, 8'd2},
        '{2'b01, 1'b0, 16'h0000, 16'h0000, 8'd6,  8'd20},
        '{2'b10, 1'b0, 16'h0000, 16'h0000, 8'd12, 8'd12},
        '{2'b10, 1'b0, 16'h0000, 16'h0000, 8'd3,  8'd10},
        '{2'b00, 1'b1, 16'h0104, 16'h010A, 8'd14, 8'd2},
        '{2'b01, 1'b1, 16'h0108, 16'h010F, 8'd2,  8'd20},
        '{2'b10, 1'b1, 16'h0100, 16'h01FF, 8'd4,  8'd9},
        '{2'b11, 1'b0, 16'h0000, 16'h0000, 8'd3,  8'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic             qual_en = 1'b0;
    logic [PC_W-1:0]  win_lo = '0;
    logic [PC_W-1:0]  win_hi = '0;
    logic             step_valid = 1'b0;
    logic [PC_W-1:0]  step_pc = '0;
    logic [DAT_W-1:0] step_data = '0;
    logic             trig = 1'b0;
    logic             rd_start = 1'b0;
    logic             rd_next = 1'b0;
    logic [PC_W-1:0]  rd_pc;
    logic [DAT_W-1:0] rd_data;
    logic [CNT_W-1:0] count;
    logic             armed;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [PC_W-1:0]  exp_pc  [64];
    logic [DAT_W-1:0] exp_dat [64];
    int n_exp;

    trc_buffer #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W),
        .DAT_W (DAT_W)
    ) i_trc_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .mode       (mode),
        .qual_en    (qual_en),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .step_valid (step_valid),
        .step_pc    (step_pc),
        .step_data  (step_data),
        .trig       (trig),
        .rd_start   (rd_start),
        .rd_next    (rd_next),
        .rd_pc      (rd_pc),
        .rd_data    (rd_data),
        .count      (count),
        .armed      (armed),
        .done       (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic do_arm(input logic [1:0] m);
        @(negedge clk);
        arm  = 1'b1;
        mode = m;
        @(negedge clk);
        arm = 1'b0;
    endtask

    // Drive n steps, pc = 0x100 + i, data = ~i; trigger on step index tidx.
    task automatic drive_steps(input int n, input int tidx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_valid = 1'b1;
            step_pc    = PC_W'(16'h0100 + i);
            step_data  = ~DAT_W'(i);
            trig       = (i == tidx);
        end
        @(negedge clk);
        step_valid = 1'b0;
        trig       = 1'b0;
    endtask

    // Read out n entries oldest first and compare against the model.
    task automatic read_all(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            rd_start = (k == 0);
            rd_next  = (k != 0);
            @(posedge clk);
            @(negedge clk);
            rd_start = 1'b0;
            rd_next  = 1'b0;
            check({req, " R8 pc"}, 32'(rd_pc), 32'(exp_pc[k]));
            check({req, " R8 data"}, 32'(rd_data), 32'(exp_dat[k]));
        end
    endtask

    task automatic run_case(input case_t c);
        logic [PC_W-1:0]  all_pc  [64];
        logic [DAT_W-1:0] all_dat [64];
        int nw = 0;
        int taken = 0;
        int budget;
        int keep;
        logic exp_done;
        budget = (c.mode == 2'b01) ? DEPTH : (c.mode == 2'b10) ? DEPTH / 2 : 0;
        for (int i = 0; i < int'(c.npre) + int'(c.npost); i++) begin
            logic [PC_W-1:0] pc;
            logic ok;
            pc = PC_W'(16'h0100 + i);
            ok = !c.qual || (pc >= c.lo && pc <= c.hi);
            if (ok && i < int'(c.npre) && c.mode != 2'b01) begin
                all_pc[nw] = pc; all_dat[nw] = ~DAT_W'(i); nw++;
            end else if (ok && i >= int'(c.npre) && taken < budget) begin
                all_pc[nw] = pc; all_dat[nw] = ~DAT_W'(i); nw++; taken++;
            end
        end
        exp_done = (budget == 0) || (taken == budget);
        keep  = (nw > DEPTH) ? DEPTH : nw;
        n_exp = keep;
        for (int k = 0; k < keep; k++) begin
            exp_pc[k]  = all_pc[nw - keep + k];
            exp_dat[k] = all_dat[nw - keep + k];
        end
        qual_en = c.qual;
        win_lo  = c.lo;
        win_hi  = c.hi;
        do_arm(c.mode);
        check("R2 count cleared on arm", 32'(count), 32'd0);
        check("R2 armed after arm", 32'(armed), 32'd1);
        drive_steps(int'(c.npre) + int'(c.npost), int'(c.npre));
        check("R3 R4 R5 R6 R7 R11 count", 32'(count), 32'(keep));
        check("R3 R4 R5 R11 done", 32'(done), 32'(exp_done));
        read_all(keep, "R6 R7 entry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 count", 32'(count), 32'd0);
        check("R1 armed", 32'(armed), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: trigger while disarmed has no effect.
        drive_steps(4, 1);
        check("R9 idle trig count", 32'(count), 32'd0);
        check("R9 idle trig done", 32'(done), 32'd0);

        // Vector table.
        for (int ci = 0; ci < NCASE; ci++) begin
            run_case(CASES[ci]);
        end

        // R9: trigger after done, with steps, leaves capture intact.
        run_case(CASES[0]);
        drive_steps(6, 2);
        check("R9 frozen count", 32'(count), 32'd5);
        check("R9 frozen done", 32'(done), 32'd1);
        read_all(n_exp, "R9 frozen entry");

        // R10: armed, no valid steps, then trigger in stop-at-trigger mode.
        qual_en = 1'b0;
        do_arm(2'b00);
        repeat (5) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        check("R10 no write count", 32'(count), 32'd0);
        check("R3 done after trig", 32'(done), 32'd1);

        // R2: arm wins over a simultaneous trigger.
        @(negedge clk);
        arm  = 1'b1;
        trig = 1'b1;
        mode = 2'b00;
        @(negedge clk);
        arm  = 1'b0;
        trig = 1'b0;
        check("R2 arm priority armed", 32'(armed), 32'd1);
        check("R2 arm priority done", 32'(done), 32'd0);

        finish_run();
    end

endmodule